// File: doc/BRIEF.md
# Flash Program/Erase Status Reporter

This block sits between a flash array's read path and the host bus. While an embedded program or erase runs, it replaces the array data with a status word. The host polls this word to learn whether the operation is still running, whether it finished, and whether it failed. Once the device is back in read mode, array data passes through untouched. The block also drives a `readMode` control that the surrounding device uses to decide when normal array reads resume.

A two-bit configuration value picks one of two status styles. In style 00, bit 7 returns the inverse of the loaded data's bit 7 while a program runs, and 0 while an erase runs. A successful operation returns to read mode on its own. In style 01, bit 7 is a plain "finished" flag. Any completed operation then waits for an exit command. A failed operation, or one that saw the programming supply drop, always waits for the exit command, whichever style is selected.

There are two resets. The power-up reset clears everything, including the configuration. The device reset pin aborts the current operation but keeps the configuration.

Top module: `flash_status_top`

## Requirements
- R1: The configuration is 00 after power-up reset. A write of 00 or 01 in read mode takes effect. A write whose upper bit is 1 leaves the configuration unchanged.
- R2: In read mode `readMode` is 1 and `readData` equals `arrayData` in the same cycle.
- R3: With configuration 00, bit 7 of `readData` is the inverse of bit 7 of `lastData` captured at the start of a program. During an erase, bit 7 is 0.
- R4: With configuration 01, bit 7 is 0 while the operation is active. It is 1 once the operation has completed and the block is waiting for the exit command.
- R5: Bit 6 starts at 0 when an operation starts and inverts after every read strobe while the operation is active. It holds its value once the operation has completed.
- R6: Bit 2 starts at 0 and inverts after every read strobe only during an active erase. It stays 0 during a program.
- R7: With configuration 00, a completion with no failure and a good supply returns `readMode` to 1 in the cycle after `opDone`.
- R8: With configuration 01, after a completion the block stays out of read mode until `idExit`. It returns to read mode in the cycle after `idExit`.
- R9: A completion with `opFail` = 1, or with `vppOk` low at any time during the operation, waits for `idExit` under either configuration. Bit 5 reads 1 after `opFail`. Bit 3 reads 1 once `vppOk` was seen low. Both bits hold until `idExit`.
- R10: A configuration write while an operation is active, or while the block waits for exit, has no effect.
- R11: `pinRst_n` low returns the block to read mode and clears the status flags, but keeps the configuration.
- R12: Outside read mode, all bits of `readData` other than 7, 6, 5, 3 and 2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRst_n | input | 1 | Power-up reset, active low, synchronous; clears the configuration too |
| pinRst_n | input | 1 | Device reset pin, active low, synchronous; keeps the configuration |
| opBusy | input | 1 | Embedded operation running; sampled in read mode to start status reporting |
| opIsErase | input | 1 | Operation type at start: 1 erase, 0 program |
| lastData | input | DATA_W | Data word loaded by the last program command |
| opDone | input | 1 | One-cycle completion pulse |
| opFail | input | 1 | Qualifies `opDone`: the operation could not be verified |
| vppOk | input | 1 | Programming supply is adequate |
| readStrobe | input | 1 | One-cycle host read access |
| arrayData | input | DATA_W | Data read from the array |
| cfgWrite | input | 1 | Configuration write command pulse |
| cfgData | input | 2 | Value for a configuration write |
| idExit | input | 1 | Exit command pulse; leaves the waiting state |
| readData | output | DATA_W | Data presented to the host |
| readMode | output | 1 | 1 while the device is in normal read mode |

## Verification
Both outputs are built combinationally from registered state. Everything sampled at a clock edge shows up in the cycle that follows:
- Status replaces array data one cycle after the edge that samples `opBusy`.
- A toggle bit changes one cycle after its read strobe.
- `readMode` rises one cycle after `opDone` or `idExit`.

Array data itself passes through in the same cycle. The bench drives inputs 1 ns after each rising edge. A behavioural model advances on the same edge, and both outputs are compared at every falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef enum logic [1:0] {
    ST_READ   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_HOLD   = 2'd2
  } statusState_t;

  // configuration values
  localparam logic [1:0] CFG_AUTO = 2'b00;
  localparam logic [1:0] CFG_EXIT = 2'b01;

  // status bit positions decoded by host software
  localparam int POLL_BIT      = 7;
  localparam int TOGGLE_BIT    = 6;
  localparam int ERR_BIT       = 5;
  localparam int VPP_BIT       = 3;
  localparam int ERASE_TOG_BIT = 2;

  typedef struct packed {
    logic clearAll;    // wipe operation state
    logic startOp;     // capture type and data, zero toggles and flags
    logic readTick;    // a read hit an active operation
    logic vppWatch;    // supply is being watched
    logic setErr;      // completion with failure
    logic showStatus;  // present status instead of array data
    logic doneHigh;    // bit 7 forced high (finished, exit style)
    logic pollMode;    // bit 7 uses complement polling
  } statusStrobe_t;

endpackage

// File: rtl/fsc_ctrl.sv
module fsc_ctrl
  import flash_status_pkg::*;
(
  input  logic          clk,
  input  logic          porRst_n,
  input  logic          pinRst_n,
  input  logic          opBusy,
  input  logic          opDone,
  input  logic          opFail,
  input  logic          vppOk,
  input  logic          readStrobe,
  input  logic          cfgWrite,
  input  logic [1:0]    cfgData,
  input  logic          idExit,
  input  logic          vppFlag,
  output statusStrobe_t strobe,
  output logic          readMode,
  output statusState_t  stateOut,
  output logic [1:0]    cfgOut
);

  statusState_t state, nextState;
  logic [1:0]   cfgReg;
  logic         failNow;
  logic         cfgLegal;

  assign failNow  = opFail | ~vppOk | vppFlag;
  assign cfgLegal = (cfgData == CFG_AUTO) || (cfgData == CFG_EXIT);

  always_ff @(posedge clk) begin
    if (!porRst_n) begin
      cfgReg <= CFG_AUTO;
    end else if (pinRst_n && cfgWrite && cfgLegal && state == ST_READ) begin
      cfgReg <= cfgData;
    end
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_READ:   if (opBusy) nextState = ST_ACTIVE;
      ST_ACTIVE: if (opDone) nextState = (failNow || cfgReg == CFG_EXIT) ? ST_HOLD : ST_READ;
      ST_HOLD:   if (idExit) nextState = ST_READ;
      default:   nextState = ST_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!porRst_n || !pinRst_n) begin
      state <= ST_READ;
    end else begin
      state <= nextState;
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.clearAll   = ~porRst_n | ~pinRst_n | (state == ST_HOLD && idExit);
    strobe.startOp    = (state == ST_READ) && opBusy;
    strobe.readTick   = (state == ST_ACTIVE) && readStrobe;
    strobe.vppWatch   = (state == ST_ACTIVE);
    strobe.setErr     = (state == ST_ACTIVE) && opDone && opFail;
    strobe.showStatus = (state != ST_READ);
    strobe.doneHigh   = (state == ST_HOLD) && (cfgReg == CFG_EXIT);
    strobe.pollMode   = (cfgReg == CFG_AUTO);
  end

  assign readMode = (state == ST_READ);
  assign stateOut = state;
  assign cfgOut   = cfgReg;

endmodule

// File: rtl/fsc_datapath.sv
module fsc_datapath
  import flash_status_pkg::*;
#(
  parameter int DATA_W = 16
)(
  input  logic              clk,
  input  statusStrobe_t     strobe,
  input  logic              opIsErase,
  input  logic [DATA_W-1:0] lastData,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              vppOk,
  output logic [DATA_W-1:0] readData,
  output logic              vppFlag
);

  logic isErase;
  logic pollRef;
  logic togMain;
  logic togErase;
  logic errFlag;
  logic vppLow;
  logic [DATA_W-1:0] statusWord;

  always_ff @(posedge clk) begin
    if (strobe.clearAll) begin
      isErase  <= 1'b0;
      pollRef  <= 1'b0;
      togMain  <= 1'b0;
      togErase <= 1'b0;
      errFlag  <= 1'b0;
      vppLow   <= 1'b0;
    end else if (strobe.startOp) begin
      isErase  <= opIsErase;
      pollRef  <= ~lastData[POLL_BIT];
      togMain  <= 1'b0;
      togErase <= 1'b0;
      errFlag  <= 1'b0;
      vppLow   <= 1'b0;
    end else begin
      if (strobe.readTick) begin
        togMain <= ~togMain;
        if (isErase) togErase <= ~togErase;
      end
      if (strobe.vppWatch && !vppOk) vppLow <= 1'b1;
      if (strobe.setErr) errFlag <= 1'b1;
    end
  end

  always_comb begin
    statusWord                = '0;
    statusWord[POLL_BIT]      = strobe.doneHigh | (strobe.pollMode & ~isErase & pollRef);
    statusWord[TOGGLE_BIT]    = togMain;
    statusWord[ERR_BIT]       = errFlag;
    statusWord[VPP_BIT]       = vppLow;
    statusWord[ERASE_TOG_BIT] = togErase;
  end

  assign readData = strobe.showStatus ? statusWord : arrayData;
  assign vppFlag  = vppLow;

endmodule

// File: rtl/flash_status_top.sv
module flash_status_top
  import flash_status_pkg::*;
#(
  parameter int DATA_W = 16
)(
  input  logic              clk,
  input  logic              porRst_n,
  input  logic              pinRst_n,
  input  logic              opBusy,
  input  logic              opIsErase,
  input  logic [DATA_W-1:0] lastData,
  input  logic              opDone,
  input  logic              opFail,
  input  logic              vppOk,
  input  logic              readStrobe,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              cfgWrite,
  input  logic [1:0]        cfgData,
  input  logic              idExit,
  output logic [DATA_W-1:0] readData,
  output logic              readMode
);

  statusStrobe_t strobe;
  statusState_t  stateNow;
  logic [1:0]    cfgNow;
  logic          vppFlagNow;

  fsc_ctrl uCtrl (
    .clk        (clk),
    .porRst_n   (porRst_n),
    .pinRst_n   (pinRst_n),
    .opBusy     (opBusy),
    .opDone     (opDone),
    .opFail     (opFail),
    .vppOk      (vppOk),
    .readStrobe (readStrobe),
    .cfgWrite   (cfgWrite),
    .cfgData    (cfgData),
    .idExit     (idExit),
    .vppFlag    (vppFlagNow),
    .strobe     (strobe),
    .readMode   (readMode),
    .stateOut   (stateNow),
    .cfgOut     (cfgNow)
  );

  fsc_datapath #(.DATA_W(DATA_W)) uDp (
    .clk       (clk),
    .strobe    (strobe),
    .opIsErase (opIsErase),
    .lastData  (lastData),
    .arrayData (arrayData),
    .vppOk     (vppOk),
    .readData  (readData),
    .vppFlag   (vppFlagNow)
  );

endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk
  import flash_status_pkg::*;
#(
  parameter int DATA_W = 16
)(
  input logic              clk,
  input logic              porRst_n,
  input logic              pinRst_n,
  input logic              readStrobe,
  input logic              opDone,
  input logic              opFail,
  input logic              vppOk,
  input logic              idExit,
  input logic              cfgWrite,
  input logic [1:0]        cfgData,
  input logic [DATA_W-1:0] arrayData,
  input logic [DATA_W-1:0] readData,
  input logic              readMode,
  input statusState_t      state,
  input logic [1:0]        cfgReg,
  input logic              vppFlag
);

  localparam logic [DATA_W-1:0] STATUS_MASK =
      (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOGGLE_BIT) | (DATA_W'(1) << ERR_BIT) |
      (DATA_W'(1) << VPP_BIT)  | (DATA_W'(1) << ERASE_TOG_BIT);

  // R1
  cfg_legal_chk: assert property (@(posedge clk) disable iff (!porRst_n)
    (cfgWrite && cfgData[1]) |=> $stable(cfgReg));

  // R2
  passthru_chk: assert property (@(posedge clk) disable iff (!porRst_n)
    readMode |-> (readData == arrayData));

  // R4
  done_high_chk: assert property (@(posedge clk) disable iff (!porRst_n || !pinRst_n)
    (state == ST_HOLD && cfgReg == CFG_EXIT) |-> readData[POLL_BIT]);

  // R5
  toggle_chk: assert property (@(posedge clk) disable iff (!porRst_n || !pinRst_n)
    (state == ST_ACTIVE && readStrobe && !opDone) |=> (readData[TOGGLE_BIT] != $past(readData[TOGGLE_BIT])));

  // R7
  auto_return_chk: assert property (@(posedge clk) disable iff (!porRst_n || !pinRst_n)
    (state == ST_ACTIVE && opDone && !opFail && vppOk && !vppFlag && cfgReg == CFG_AUTO) |=> readMode);

  // R8
  exit_wait_chk: assert property (@(posedge clk) disable iff (!porRst_n || !pinRst_n)
    (state == ST_HOLD && !idExit) |=> !readMode);

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!porRst_n || !pinRst_n)
    (!readMode && readData[ERR_BIT]) |=> (readMode || readData[ERR_BIT]));

  // R11
  cfg_keep_chk: assert property (@(posedge clk) disable iff (!porRst_n)
    !pinRst_n |=> $stable(cfgReg));

  // R12
  quiet_bits_chk: assert property (@(posedge clk) disable iff (!porRst_n)
    !readMode |-> ((readData & ~STATUS_MASK) == '0));

endmodule

bind flash_status_top flash_status_chk #(.DATA_W(DATA_W)) uChk (
  .clk        (clk),
  .porRst_n   (porRst_n),
  .pinRst_n   (pinRst_n),
  .readStrobe (readStrobe),
  .opDone     (opDone),
  .opFail     (opFail),
  .vppOk      (vppOk),
  .idExit     (idExit),
  .cfgWrite   (cfgWrite),
  .cfgData    (cfgData),
  .arrayData  (arrayData),
  .readData   (readData),
  .readMode   (readMode),
  .state      (stateNow),
  .cfgReg     (cfgNow),
  .vppFlag    (vppFlagNow)
);

// File: tb/tb_flash_status_top.sv
`timescale 1ns/1ps
module tb_flash_status_top;

  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic porRst_n = 1'b0, pinRst_n = 1'b1;
  logic opBusy = 1'b0, opIsErase = 1'b0, opDone = 1'b0, opFail = 1'b0;
  logic vppOk = 1'b1, readStrobe = 1'b0, cfgWrite = 1'b0, idExit = 1'b0;
  logic [1:0] cfgData = 2'b00;
  logic [DATA_W-1:0] lastData = '0, arrayData = 16'h1234;
  logic [DATA_W-1:0] readData;
  logic readMode;

  int checkCnt = 0, failCnt = 0;
  bit finished = 0;
  string curReq = "R2";

  always #2 clk = ~clk;

  flash_status_top #(.DATA_W(DATA_W)) dut (
    .clk(clk), .porRst_n(porRst_n), .pinRst_n(pinRst_n), .opBusy(opBusy),
    .opIsErase(opIsErase), .lastData(lastData), .opDone(opDone), .opFail(opFail),
    .vppOk(vppOk), .readStrobe(readStrobe), .arrayData(arrayData),
    .cfgWrite(cfgWrite), .cfgData(cfgData), .idExit(idExit),
    .readData(readData), .readMode(readMode)
  );

  // behavioural reference: 0 read, 1 active, 2 waiting for exit
  int mSt = 0;
  bit [1:0] mCfg = 0;
  bit mErase, mD7, mT6, mT2, mErr, mVpp;

  always @(posedge clk) begin
    if (!porRst_n || !pinRst_n) begin
      if (!porRst_n) mCfg = 0;
      mSt = 0; mT6 = 0; mT2 = 0; mErr = 0; mVpp = 0;
    end else begin
      case (mSt)
        0: begin
          if (cfgWrite && !cfgData[1]) mCfg = cfgData;
          if (opBusy) begin
            mSt = 1; mErase = opIsErase; mD7 = lastData[7];
            mT6 = 0; mT2 = 0; mErr = 0; mVpp = 0;
          end
        end
        1: begin
          if (readStrobe) begin
            mT6 = !mT6;
            if (mErase) mT2 = !mT2;
          end
          if (!vppOk) mVpp = 1;
          if (opDone) begin
            if (opFail) mErr = 1;
            mSt = (opFail || mVpp || mCfg == 1) ? 2 : 0;
          end
        end
        default: if (idExit) begin
          mSt = 0; mT6 = 0; mT2 = 0; mErr = 0; mVpp = 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    logic [DATA_W-1:0] expD;
    logic expRm;
    if (porRst_n && !finished) begin
      expRm = (mSt == 0);
      if (expRm) expD = arrayData;
      else begin
        expD = '0;
        expD[7] = (mSt == 2 && mCfg == 1) ? 1'b1 : ((mCfg == 0 && !mErase) ? !mD7 : 1'b0);
        expD[6] = mT6; expD[5] = mErr; expD[3] = mVpp; expD[2] = mT2;
      end
      checkCnt++;
      if (readData !== expD || readMode !== expRm) begin
        failCnt++;
        $display("FAIL %s readData=%h readMode=%b expected readData=%h readMode=%b",
                 curReq, readData, readMode, expD, expRm);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
    arrayData = arrayData + 16'h1357;
    readStrobe = 0; opDone = 0; opFail = 0; cfgWrite = 0; idExit = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic startOp(bit erase, logic [DATA_W-1:0] d);
    opIsErase = erase; lastData = d; opBusy = 1; cyc();
  endtask

  task automatic reads(int n);
    for (int i = 0; i < n; i++) begin readStrobe = 1; cyc(); cyc(); end
  endtask

  task automatic finishOp(bit fail);
    opDone = 1; opFail = fail; opBusy = 0; cyc();
  endtask

  task automatic writeCfg(logic [1:0] v);
    cfgWrite = 1; cfgData = v; cyc();
  endtask

  initial begin
    idle(3);
    porRst_n = 1;
    curReq = "R2 reset/passthrough"; idle(4);
    curReq = "R3 R5 R6 R7 R12 program cfg00"; startOp(0, 16'h0080); reads(5); finishOp(0); idle(3);
    curReq = "R3 R5 R6 R7 program d7=0"; startOp(0, 16'h7f00); reads(2); finishOp(0); idle(2);
    curReq = "R3 R6 erase cfg00"; startOp(1, 16'hffff); reads(4); finishOp(0); idle(3);
    curReq = "R1 illegal cfg ignored"; writeCfg(2'b11); writeCfg(2'b10); idle(1);
    startOp(0, 16'h0000); reads(1); finishOp(0); idle(2);
    curReq = "R1 R4 cfg01 program"; writeCfg(2'b01); idle(1);
    startOp(0, 16'h0080); reads(3);
    curReq = "R10 cfg write during active"; writeCfg(2'b00); reads(1); finishOp(0);
    curReq = "R5 R8 R10 wait for exit"; reads(3); writeCfg(2'b00); idle(3);
    curReq = "R8 exit"; idExit = 1; cyc(); idle(2);
    curReq = "R4 R6 cfg01 erase"; startOp(1, 16'h0000); reads(3); finishOp(0); idle(2); idExit = 1; cyc();
    curReq = "R9 fail cfg01"; startOp(0, 16'h00ff); reads(2); finishOp(1); reads(2); idle(2); idExit = 1; cyc(); idle(2);
    curReq = "R1 back to cfg00"; writeCfg(2'b00); idle(1);
    curReq = "R9 fail cfg00"; startOp(1, 16'h0000); reads(2); finishOp(1); reads(2); idle(3); idExit = 1; cyc(); idle(2);
    curReq = "R9 vpp low cfg00"; startOp(0, 16'h0080); reads(1); vppOk = 0; cyc(); vppOk = 1; reads(2); finishOp(0); idle(3);
    idExit = 1; cyc(); idle(2);
    curReq = "R9 vpp low at completion"; startOp(0, 16'h0000); reads(1); vppOk = 0; finishOp(0); vppOk = 1; idle(2); idExit = 1; cyc();
    curReq = "R11 pin reset keeps cfg"; writeCfg(2'b01); startOp(0, 16'h0080); reads(2);
    pinRst_n = 0; cyc(); cyc(); pinRst_n = 1; idle(2);
    startOp(0, 16'h0080); reads(1); finishOp(0); idle(2); idExit = 1; cyc(); idle(1);
    curReq = "R1 power reset clears cfg"; porRst_n = 0; cyc(); cyc(); porRst_n = 1; idle(2);
    startOp(0, 16'h0080); reads(2); finishOp(0); idle(3);
    finished = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      checkCnt++; failCnt++;
      $display("FAIL watchdog %s actual=hung expected=complete", curReq);
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

endmodule